// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block generates serial management frames for PHY devices on a two-wire management bus (MDC clock, MDIO data). Software programs a 32-bit frame register over a simple register bus: start delimiter, opcode, PHY address, register address, turnaround and 16 data bits. Each accepted write to that register starts one frame. The frame goes out as a 32-bit preamble of ones, then the frame bits, most significant first, one bit per MDC period. All fields go out exactly as written, including the two opcodes that do not follow the management standard.

For opcodes whose upper bit is set (read types), the engine releases MDIO after the register address. It then samples 16 data bits from the PHY and writes them into the low half of the frame register, where software reads them back. A second register sets the MDC divider. A divider of zero holds off frame generation. A frame write made while the divider is zero is stored, and it is launched by the first later write of a non-zero divider. Each frame ends with a single-cycle completion pulse.

The register bus has no handshake: a write is taken on the clock edge where `bus_we` is high, and read data is combinational from `bus_addr`. MDIO is modelled as separate in, out and output-enable pins. The pad buffer is outside this block.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy` and `done` are low, and the speed register (address 1) reads back as zero.
- R2: With speed S non-zero, a write to address 0 sets `busy` on the next clock edge. The block drives 64 bit periods with `mdio_oe` high: 32 ones, then frame register bits 31 down to 0. This applies when frame bit 29 is 0, which covers opcodes 01 and 00.
- R3: When frame bit 29 is 1 (opcodes 10 and 11), the block drives the first 46 bit periods: the preamble and frame bits 31 down to 18. It holds `mdio_oe` low for the last 18 bit periods.
- R4: For a frame with bit 29 set, the block samples `mdio_in` on the MDC rising edge of bit periods 48 to 63. These bits, first one most significant, replace frame register bits 15..0. Bits 31..16 are unchanged.
- R5: While a frame runs, MDC is low for S clocks and then high for S clocks in each bit period. The first rise comes S+1 edges after the accepting edge. `mdio_out` changes only where MDC falls.
- R6: `done` is high for exactly one cycle, after clock edge 128·S+1 counted from the accepting edge. `busy` falls on that same edge.
- R7: A frame write made while S is zero produces no MDC activity. A later non-zero speed write launches the stored frame, with R2/R3/R5/R6 timing counted from the speed write edge.
- R8: A write to address 0 while `busy` is high is ignored. The frame register keeps its value and no second frame follows.
- R9: `bus_rdata` returns the frame register at address 0. At address 1 it returns the speed value, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = frame register, 1 = speed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| mdio_in | input | 1 | MDIO value from the pad |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
Every timing result is counted in clock edges from the edge that accepts the launching write (the frame write, or the speed write for a deferred frame). `busy` rises one edge later. The first MDC rise lands S+1 edges after, later rises follow every 2·S edges, and `done` lands 128·S+1 edges after. The bench keeps a free-running edge counter and notes its value at the falling clock edge that follows the accepting edge. It samples MDIO and the counter one time unit after each MDC rise, and polls `done` at falling clock edges, so each value is read between edges. The PHY model changes `mdio_in` just after each MDC fall, a full half-period before the engine samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PREAMBLE_BITS = 32;
  localparam int REG_BITS      = 32;
  localparam int FRAME_BITS    = PREAMBLE_BITS + REG_BITS;
  localparam int IDX_W         = $clog2(FRAME_BITS);
  // header before turnaround: start(2) + opcode(2) + phy(5) + register(5)
  localparam int HDR_BITS      = 14;
  localparam int TA_FIRST      = PREAMBLE_BITS + HDR_BITS;
  localparam int DATA_FIRST    = TA_FIRST + 2;
  localparam int DATA_BITS     = 16;
  localparam int RD_FLAG_BIT   = 29;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick      = en && (cnt == div - 1'b1);
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: half periods alternate, a rise is always followed by a fall tick later
  p_tick_alternates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(rise_tick)) |-> mdc);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [REG_BITS-1:0]  frame,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_in,
  output logic                 busy,
  output logic                 mdio_out,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_BITS-1:0] cap_data
);
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    nxt;
  logic [REG_BITS-1:0] frm;
  logic                rd;
  logic                nxt_bit;

  assign nxt     = idx + 1'b1;
  assign nxt_bit = (nxt < IDX_W'(PREAMBLE_BITS)) ? 1'b1 : frm[~nxt[4:0]];

  always_ff @(posedge clk) begin
    if (start && !busy) frm <= frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      rd       <= 1'b0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
      done     <= 1'b0;
      cap_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          idx      <= '0;
          rd       <= frame[RD_FLAG_BIT];
          mdio_out <= 1'b1;
          mdio_oe  <= 1'b1;
        end
      end else begin
        if (rise_tick && rd && idx >= IDX_W'(DATA_FIRST))
          cap_data <= {cap_data[DATA_BITS-2:0], mdio_in};
        if (fall_tick) begin
          if (idx == IDX_W'(FRAME_BITS - 1)) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
          end else begin
            idx      <= nxt;
            mdio_out <= nxt_bit;
            mdio_oe  <= !(rd && nxt >= IDX_W'(TA_FIRST));
          end
        end
      end
    end
  end

  // R5: data line only moves where the clock falls
  p_mdio_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall_tick)) |-> $stable(mdio_out));
  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: a read frame never drives during the final data bits
  p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd && idx >= IDX_W'(DATA_FIRST)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        mdio_in,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done
);
  logic [REG_BITS-1:0]  frame_q;
  logic [DIV_W-1:0]     speed_q;
  logic [DIV_W-1:0]     div_run;
  logic                 pending;
  logic                 launch;
  logic                 rise_tick, fall_tick;
  logic [DATA_BITS-1:0] cap_data;
  logic                 wr_frame;

  assign wr_frame  = bus_we && !bus_addr && !busy;
  assign launch    = pending && (speed_q != '0) && !busy;
  assign bus_rdata = bus_addr ? 32'(speed_q) : frame_q;

  always_ff @(posedge clk) begin
    if (wr_frame)
      frame_q <= bus_wdata;
    else if (done && frame_q[RD_FLAG_BIT])
      frame_q[DATA_BITS-1:0] <= cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= '0;
      div_run <= '0;
      pending <= 1'b0;
    end else begin
      if (bus_we && bus_addr) speed_q <= bus_wdata[DIV_W-1:0];
      if (launch) begin
        div_run <= speed_q;
        pending <= 1'b0;
      end else if (wr_frame) begin
        pending <= 1'b1;
      end
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .div       (div_run),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (launch),
    .frame     (frame_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_in   (mdio_in),
    .busy      (busy),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .cap_data  (cap_data)
  );

  // R7: no frame starts with a zero divider
  p_no_zero_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (div_run != '0));
  // R8: header bits of the frame register hold while a frame runs
  p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_q[REG_BITS-1:DATA_BITS]));
  // R1: clock and drive idle when no frame runs
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_frame_engine_test.sv
module mdio_frame_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdio_in = 1'b0;
  logic        mdc, mdio_out, mdio_oe, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int t0 = 0;

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdio_in(mdio_in),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write at a falling edge; t0 = edge count including the accepting edge
  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    t0 = cyc;
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done(input int limit, output int took);
    took = -1;
    for (int k = 0; k < limit; k++) begin
      if (done) begin took = cyc - t0; break; end
      @(negedge clk);
    end
  endtask

  // launch one frame (by frame write, or by speed write when deferred) and check it
  task automatic run_frame(input string tag, input logic by_speed, input logic [31:0] frm,
                           input int s, input logic [15:0] pat);
    logic [63:0] got, goe, exp_bits, exp_oe;
    int rt [64];
    int took;
    logic rd;
    logic [31:0] rb;
    rd = frm[29];
    exp_bits = {32'hFFFF_FFFF, frm};
    exp_oe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    if (by_speed) bus_write(1'b1, 32'(s)); else bus_write(1'b0, frm);
    fork
      begin
        for (int i = 0; i < 64; i++) begin
          @(posedge mdc); #1;
          got[63-i] = mdio_out; goe[63-i] = mdio_oe; rt[i] = cyc;
          if (i < 63) begin
            @(negedge mdc); #1;
            if (i + 1 >= 48) mdio_in = pat[63-(i+1)];
          end
        end
      end
      wait_done(128 * s + 50, took);
    join
    check({tag, " R2/R3 drive enable"}, goe, exp_oe);
    check({tag, " R2/R3 frame bits"}, got & exp_oe, exp_bits & exp_oe);
    check({tag, " R5 first rise"}, 64'(rt[0] - t0), 64'(1 + s));
    check({tag, " R5 period"}, 64'(rt[63] - rt[0]), 64'(63 * 2 * s));
    check({tag, " R6 done edge"}, 64'(took), 64'(128 * s + 1));
    @(negedge clk);
    check({tag, " R6 done single"}, {62'h0, done, busy}, 64'h0);
    bus_read(1'b0, rb);
    check({tag, " R4 readback"}, 64'(rb), 64'(rd ? {frm[31:16], pat} : frm));
  endtask

  task automatic t_reset;
    logic [31:0] rb;
    check("R1 idle pins", {60'h0, mdc, mdio_oe, busy, done}, 64'h0);
    bus_read(1'b1, rb);
    check("R1 speed reset", 64'(rb), 64'h0);
  endtask

  task automatic t_speed_readback;
    logic [31:0] rb;
    bus_write(1'b1, 32'h0000_0025);
    bus_read(1'b1, rb);
    check("R9 speed read", 64'(rb), 64'h25);
    bus_write(1'b1, 32'h1);
    check("R9 no launch from speed", {63'h0, busy}, 64'h0);
  endtask

  task automatic t_deferred;
    logic quiet;
    bus_write(1'b1, 32'h0);
    bus_write(1'b0, 32'h5B3C_A5A5);
    quiet = 1'b1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (busy || mdc) quiet = 1'b0;
    end
    check("R7 held while zero", {63'h0, quiet}, 64'h1);
    run_frame("R7 deferred", 1'b1, 32'h5B3C_A5A5, 2, 16'h0);
  endtask

  task automatic t_ignore;
    logic [31:0] rb;
    logic quiet;
    int took;
    bus_write(1'b1, 32'h1);
    bus_write(1'b0, 32'h5123_4567);
    repeat (20) @(negedge clk);
    bus_write(1'b0, 32'h6ABC_DEF0);
    wait_done(200, took);
    bus_read(1'b0, rb);
    check("R8 frame kept", 64'(rb), 64'h5123_4567);
    quiet = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (busy || mdc) quiet = 1'b0;
    end
    check("R8 no second frame", {63'h0, quiet}, 64'h1);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_speed_readback();
    bus_write(1'b1, 32'h1);
    run_frame("R2 write op01", 1'b0, 32'h5C6A_BEEF, 1, 16'h0);
    bus_write(1'b1, 32'h3);
    run_frame("R2 write op00", 1'b0, 32'h4A8D_1234, 3, 16'h0);
    bus_write(1'b1, 32'h2);
    run_frame("R3 read op10", 1'b0, 32'h6086_0000, 2, 16'hC3A5);
    bus_write(1'b1, 32'h1);
    run_frame("R3 read op11", 1'b0, 32'h7FFF_FFFF, 1, 16'h1E81);
    t_deferred();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule